// File: doc/BRIEF.md
# Streaming Receive-Data Checker with Alternating Error Counters

This block verifies a stream of returned bytes against a table of expected bytes held in a vector memory. While the receive enable is high, the block walks the memory's read address upward from zero, one entry per clock. It compares each incoming byte with the expected byte that the memory returns for the current address. The memory read port is asynchronous, so the expected byte belongs to the address shown in the same cycle.

Every mismatch raises a registered error flag for one cycle and adds one to an error count. The count is kept in two counters that swap roles. One counter accumulates errors. The other holds the value captured at the last host read, and the host samples that held value at leisure.

A read request freezes the accumulating counter, which becomes the held value. It also restarts the other counter as the new accumulator. An error that arrives in the same cycle as the read is counted in the fresh counter, so no error is ever dropped. The hardware reports only the increments since the last read; any running total belongs to the host.

Top module: `rx_stream_checker`

## Requirements
- R1: `exp_addr` is 0 in any cycle that follows a cycle in which `rx_en` was low or reset was applied. Each clock edge that samples `rx_en` high advances it by one. A new burst therefore always starts comparing at address 0.
- R2: `err_flag` is high in the cycle after an edge that samples `rx_en` high with `rx_byte` different from `exp_byte`. In every other cycle it is low.
- R3: While `rx_en` is low, `rx_byte` and `exp_byte` have no effect: no error flag is raised and no count is added.
- R4: An edge that samples `rd_req` high makes `err_count` show the number of mismatches counted since the previous read, or since reset. The other counter restarts from 0.
- R5: When a mismatch and `rd_req` are sampled on the same edge, that mismatch is not part of the value shown on `err_count`. The restarted counter begins at 1, so the next read includes it.
- R6: The counters are 8 bits wide and wrap modulo 256. For example, 260 mismatches between reads are reported as 4.
- R7: Synchronous reset (`rst` high at an edge) clears both counters, the address and the error flag. A read right after reset reports 0.
- R8: Mismatches are accumulated across several enable bursts, including the idle gaps between them, until the next read.
- R9: `err_count` changes only after an edge that samples `rd_req` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable; bytes are compared while high |
| rx_byte | input | 8 | Returned data byte |
| exp_byte | input | 8 | Expected byte from the vector memory read port |
| rd_req | input | 1 | Host read pulse; captures the active count and swaps counters |
| exp_addr | output | 14 | Vector memory read address |
| err_flag | output | 1 | Registered per-cycle mismatch flag |
| err_count | output | 8 | Count captured at the last read |

## Verification
The bench places a read on the same edge as a mismatch. A design that lost the coincident error, or counted it in the frozen value, would report one too few on the next read or one too many on this one.

It leaves garbage on the data inputs during idle gaps. A design that compared while disabled would flag errors and add to the count.

It restarts bursts after gaps. An address that resumed where it stopped, instead of at zero, would shift every expected byte and flood the stream with false mismatches.

It drives 300 mismatches between two reads. A counter that saturated instead of wrapping would report 255 instead of 44.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction
endpackage

// File: rtl/rxc_addr_gen.sv
module rxc_addr_gen #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) st_d.addr = st_q.addr + ADDR_W'(1);
        else    st_d.addr = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr = st_q.addr;
endmodule

// File: rtl/rxc_compare.sv
module rxc_compare #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] want,
    output logic              miss,
    output logic              flag
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    // Unregistered mismatch feeds the counter pair in the same cycle.
    assign miss = en && (got != want);

    always_comb begin
        st_d      = st_q;
        st_d.flag = miss;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/rxc_err_bank.sv
module rxc_err_bank
    import rxc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    input  logic             rd,
    output logic [CNT_W-1:0] held
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic [NBANK-1:0][CNT_W-1:0] cnt;
        bank_e                       act;
    } st_t;

    st_t st_d, st_q;
    logic [NBANK-1:0][CNT_W-1:0] nxt;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic is_act;
        assign is_act = (st_q.act == bank_e'(g));
        always_comb begin
            nxt[g] = st_q.cnt[g];
            if (is_act) begin
                // Active bank freezes on a read; otherwise it counts.
                if (!rd && miss) nxt[g] = st_q.cnt[g] + CNT_W'(1);
            end else if (rd) begin
                // Standby bank restarts; a coincident miss is kept here.
                nxt[g] = miss ? CNT_W'(1) : '0;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt;
        if (rd) st_d.act = other_bank(st_q.act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.act <= BANK_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.cnt[other_bank(st_q.act)];
endmodule

// File: rtl/rx_stream_checker.sv
module rx_stream_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] exp_addr,
    output logic              err_flag,
    output logic [CNT_W-1:0]  err_count
);
    logic miss;

    rxc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .en(rx_en), .addr(exp_addr)
    );

    rxc_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst(rst), .en(rx_en), .got(rx_byte), .want(exp_byte),
        .miss(miss), .flag(err_flag)
    );

    rxc_err_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst(rst), .miss(miss), .rd(rd_req), .held(err_count)
    );
endmodule

// File: rtl/rx_stream_checker_chk.sv
module rx_stream_checker_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic [DATA_W-1:0] rx_byte,
    input logic [DATA_W-1:0] exp_byte,
    input logic              rd_req,
    input logic [ADDR_W-1:0] exp_addr,
    input logic              err_flag,
    input logic [CNT_W-1:0]  err_count
);
    assert_addr_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_en) |-> exp_addr == '0);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_en) && !$past(rst)) |-> exp_addr == $past(exp_addr) + ADDR_W'(1));

    assert_flag_on_miss_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_en && (rx_byte != exp_byte)) && !$past(rst)) |-> err_flag);

    assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_en) |-> !err_flag);

    assert_count_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_req) && !$past(rst)) |-> $stable(err_count));
endmodule

bind rx_stream_checker rx_stream_checker_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_byte(rx_byte),
    .exp_byte(exp_byte), .rd_req(rd_req), .exp_addr(exp_addr),
    .err_flag(err_flag), .err_count(err_count)
);

// File: tb/rx_stream_checker_test.sv
module rx_stream_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [7:0]  exp_byte;
    logic        rd_req = 1'b0;
    logic [13:0] exp_addr;
    logic        err_flag;
    logic [7:0]  err_count;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model state
    logic [13:0] m_addr = '0;
    logic [7:0]  m_act  = '0;
    logic [7:0]  m_hold = '0;

    // Scoreboard queues
    logic        q_err[$];
    logic [7:0]  q_hold[$];
    logic [13:0] q_addr[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    rx_stream_checker uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_byte(rx_byte),
        .exp_byte(exp_byte), .rd_req(rd_req), .exp_addr(exp_addr),
        .err_flag(err_flag), .err_count(err_count)
    );

    function automatic logic [7:0] vec(logic [13:0] a);
        return 8'(a * 37 + 5);
    endfunction

    assign exp_byte = vec(exp_addr);

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle, update the model, push expected outputs.
    task automatic step(bit en, bit bad, bit rd, string tag);
        logic mm;
        @(negedge clk);
        rx_en   = en;
        rd_req  = rd;
        rx_byte = bad ? (vec(m_addr) ^ 8'h5A) : vec(m_addr);
        mm = en && bad;
        @(posedge clk);
        if (rd) begin
            m_hold = m_act;
            m_act  = mm ? 8'd1 : 8'd0;
        end else if (mm) begin
            m_act = m_act + 8'd1;
        end
        m_addr = en ? m_addr + 14'd1 : 14'd0;
        q_err.push_back(mm);
        q_hold.push_back(m_hold);
        q_addr.push_back(m_addr);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare the design against queued expectations.
    always @(negedge clk) begin
        if (q_err.size() > 0) begin
            logic        e;
            logic [7:0]  h;
            logic [13:0] a;
            string       t;
            e = q_err.pop_front();
            h = q_hold.pop_front();
            a = q_addr.pop_front();
            t = q_tag.pop_front();
            check(err_flag === e, t, "err_flag", int'(err_flag), int'(e));
            check(err_count === h, t, "err_count", int'(err_count), int'(h));
            check(exp_addr === a, t, "exp_addr", int'(exp_addr), int'(a));
        end
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rx_byte = 8'hFF;
        rx_en   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst   = 1'b0;
        rx_en = 1'b0;
        // R7: reset state
        check(err_flag == 1'b0, "R7", "err_flag", int'(err_flag), 0);
        check(err_count == 8'd0, "R7", "err_count", int'(err_count), 0);
        check(exp_addr == 14'd0, "R7", "exp_addr", int'(exp_addr), 0);
        step(0, 0, 1, "R7");

        // R1: matching burst walks the address
        for (int i = 0; i < 10; i++) step(1, 0, 0, "R1");

        // R3: idle with wrong data
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R3");

        // R2: mixed burst restarting at 0
        for (int i = 0; i < 12; i++) step(1, (i % 3) == 1, 0, "R2");
        step(0, 1, 0, "R3");

        // R8: second burst accumulates
        for (int i = 0; i < 6; i++) step(1, i >= 4, 0, "R8");
        step(0, 0, 0, "R8");

        // R4: read captures 6 (4 + 2)
        step(0, 0, 1, "R4");
        step(0, 0, 0, "R4");

        // R5: mismatch coincides with a read
        step(1, 1, 0, "R5");
        step(1, 1, 1, "R5");
        step(1, 0, 0, "R5");
        step(0, 0, 0, "R5");
        step(0, 0, 1, "R5");

        // R4: read with nothing counted reports 0
        step(0, 0, 1, "R4");

        // R6: 300 mismatches wrap to 44
        for (int i = 0; i < 300; i++) step(1, 1, 0, "R6");
        step(0, 0, 1, "R6");

        // R9: held value steady without reads
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R9");
        step(0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule